// File: doc/BRIEF.md
# Multi-Core Boot Release Controller

This block sits in front of a small cluster of embedded processor cores. Before any core runs, software programs each core's start address and sets an enable mask. The cores leave reset only when software writes a separate start command. Cores whose mask bit is clear stay in reset. This lets one core be kept back for another job while the rest boot.

Once released, a core stays released until the block itself is reset. The address it started from is frozen at the moment of release, so later reprogramming cannot move a core that is already running. The same register port also gives read-only access to each core's program counter, stack pointer and link register, which the cores supply as inputs. The register port is a plain control interface with no back-pressure. Writes take effect at the clock edge where the write enable is sampled. A read returns its data one cycle after the read enable, together with a valid strobe.

Top module: `core_boot_ctrl`

## Requirements
- R1: After reset, every `core_run` bit is 0, every `core_boot_addr` lane is 0, the mask and all start-address registers read 0, and `reg_rvalid` is 0.
- R2: The mask register at byte address 0x1004 stores the low 8 bits of a write. A read returns those 8 bits, with bits 31..8 equal to 0.
- R3: The start-address register of core n (n = 0..3) is at byte address 0x1020 + 4n. It stores and reads back all 32 bits.
- R4: A write to the start register at 0x1000 with data bit 0 = 1 sets `core_run[n]` for every core n whose mask bit n is 1. The bit is set in the cycle after the write. A start write with bit 0 = 0 releases nothing, and mask bits 7..4 release nothing.
- R5: A read of the start register at 0x1000 returns 0.
- R6: A `core_run` bit that is 1 stays 1 until reset. A later start command can only add cores.
- R7: With mask 0xF7, a start command releases cores 0, 1 and 2, and core 3 stays in reset.
- R8: While a core is held in reset, its `core_boot_addr` lane follows its stored start address. From release onward the lane holds the value stored at the release edge. A later write to that core's start-address register is still stored and read back, but the lane does not change.
- R9: A read at byte address 0x100·n + 0, + 4 or + 8 returns core n's `dbg_pc`, `dbg_sp` or `dbg_lr` lane, as sampled in the read cycle.
- R10: `reg_rvalid` is 1 exactly in the cycle after `reg_rd_en`. Reads of unmapped addresses return 0. Unmapped addresses include any address with bits 1..0 nonzero, debug offsets 0x0C and above, and cluster offsets other than 0x00, 0x04 and 0x20..0x2C.
- R11: Writes to debug windows or to unmapped addresses change no register, no `core_run` bit and no boot lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 16 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd_en |
| dbg_pc | input | 128 | Program counter of each core, 32 bits per core, core 0 in the low lane |
| dbg_sp | input | 128 | Stack pointer of each core |
| dbg_lr | input | 128 | Link register of each core |
| core_run | output | 4 | Reset release per core, 1 = running |
| core_boot_addr | output | 128 | Start address per core, core 0 in the low lane |

## Verification
The hardest case to reach from the ports is a core that has already been released and then has its start address rewritten. The lane must keep its frozen value even though the register reads back the new one. The stimulus reaches this case in two ways. Directed steps release part of the cluster and then rewrite addresses of both running and held cores. Random stimulus then mixes mask writes, address writes, start commands with either value of bit 0, and reads over a reset boundary. This covers both orders of "address change, then release" and "release, then address change".

// File: rtl/core_boot_pkg.sv
package core_boot_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_TRIG,
    RK_CFG,
    RK_BASE,
    RK_DBG
  } reg_kind_e;

  localparam logic [7:0] OFF_TRIG  = 8'h00;
  localparam logic [7:0] OFF_CFG   = 8'h04;
  localparam logic [7:0] OFF_BASE0 = 8'h20;
  localparam int         DBG_WORDS = 3;

  function automatic int idx_width(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/core_boot_decode.sv
module core_boot_decode
  import core_boot_pkg::*;
#(
  parameter int              NUM_CORES    = 4,
  parameter int              ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] CLUSTER_BASE = 16'h1000,
  localparam int             IDX_W        = idx_width(NUM_CORES)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        word
);

  localparam int              PAGE_W   = ADDR_W - 8;
  localparam logic [PAGE_W-1:0] CL_PAGE = CLUSTER_BASE[ADDR_W-1:8];
  localparam logic [7:0]      BASE_END = 8'(32 + 4 * NUM_CORES);
  localparam logic [7:0]      DBG_END  = 8'(4 * DBG_WORDS);

  logic [PAGE_W-1:0] page;
  logic [7:0]        off;

  assign page = addr[ADDR_W-1:8];
  assign off  = addr[7:0];

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    word = '0;
    if (off[1:0] == 2'b00) begin
      if (page == CL_PAGE) begin
        if (off == OFF_TRIG) begin
          kind = RK_TRIG;
        end else if (off == OFF_CFG) begin
          kind = RK_CFG;
        end else if (off >= OFF_BASE0 && off < BASE_END) begin
          kind = RK_BASE;
          idx  = IDX_W'((off - OFF_BASE0) >> 2);
        end
      end else if (page < PAGE_W'(NUM_CORES) && off < DBG_END) begin
        kind = RK_DBG;
        idx  = IDX_W'(page);
        word = off[3:2];
      end
    end
  end

endmodule

// File: rtl/core_boot_regs.sv
module core_boot_regs
  import core_boot_pkg::*;
#(
  parameter int  NUM_CORES = 4,
  parameter int  CFG_W     = 8,
  localparam int IDX_W     = idx_width(NUM_CORES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  reg_kind_e                     kind,
  input  logic [IDX_W-1:0]              idx,
  input  logic [31:0]                   wdata,
  output logic [CFG_W-1:0]              cfg_q,
  output logic [NUM_CORES-1:0][31:0]    base_q,
  output logic                          trig_fire
);

  logic cfg_we;
  logic base_we;

  assign cfg_we    = wr_en && (kind == RK_CFG);
  assign base_we   = wr_en && (kind == RK_BASE);
  assign trig_fire = wr_en && (kind == RK_TRIG) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= wdata[CFG_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
      end else if (base_we && idx == IDX_W'(g)) begin
        base_q[g] <= wdata;
      end
    end
  end

endmodule

// File: rtl/core_boot_lane.sv
module core_boot_lane (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [31:0] base,
  output logic        run,
  output logic [31:0] vec
);

  logic        run_q;
  logic [31:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cap_q <= '0;
    end else if (go && !run_q) begin
      run_q <= 1'b1;
      cap_q <= base;
    end
  end

  assign run = run_q;
  assign vec = run_q ? cap_q : base;

endmodule

// File: rtl/core_boot_rdmux.sv
module core_boot_rdmux
  import core_boot_pkg::*;
#(
  parameter int  NUM_CORES = 4,
  parameter int  CFG_W     = 8,
  localparam int IDX_W     = idx_width(NUM_CORES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  reg_kind_e                  kind,
  input  logic [IDX_W-1:0]           idx,
  input  logic [1:0]                 word,
  input  logic [CFG_W-1:0]           cfg_q,
  input  logic [NUM_CORES-1:0][31:0] base_q,
  input  logic [NUM_CORES-1:0][31:0] pc_arr,
  input  logic [NUM_CORES-1:0][31:0] sp_arr,
  input  logic [NUM_CORES-1:0][31:0] lr_arr,
  output logic [31:0]                rdata,
  output logic                       rvalid
);

  logic [31:0] sel_data;

  always_comb begin
    sel_data = '0;
    unique case (kind)
      RK_CFG:  sel_data = 32'(cfg_q);
      RK_BASE: sel_data = base_q[idx];
      RK_DBG: begin
        case (word)
          2'd0:    sel_data = pc_arr[idx];
          2'd1:    sel_data = sp_arr[idx];
          2'd2:    sel_data = lr_arr[idx];
          default: sel_data = '0;
        endcase
      end
      default: sel_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        rdata <= sel_data;
      end
    end
  end

endmodule

// File: rtl/core_boot_ctrl.sv
module core_boot_ctrl
  import core_boot_pkg::*;
#(
  parameter int                NUM_CORES    = 4,
  parameter int                ADDR_W       = 16,
  parameter int                CFG_W        = 8,
  parameter logic [ADDR_W-1:0] CLUSTER_BASE = 16'h1000,
  localparam int               IDX_W        = idx_width(NUM_CORES),
  localparam int               LANES_W      = NUM_CORES * 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               reg_rvalid,
  input  logic [LANES_W-1:0] dbg_pc,
  input  logic [LANES_W-1:0] dbg_sp,
  input  logic [LANES_W-1:0] dbg_lr,
  output logic [NUM_CORES-1:0] core_run,
  output logic [LANES_W-1:0] core_boot_addr
);

  reg_kind_e                  kind;
  logic [IDX_W-1:0]           idx;
  logic [1:0]                 word;
  logic [CFG_W-1:0]           cfg_q;
  logic [NUM_CORES-1:0][31:0] base_q;
  logic [NUM_CORES-1:0][31:0] vec_arr;
  logic [NUM_CORES-1:0][31:0] pc_arr;
  logic [NUM_CORES-1:0][31:0] sp_arr;
  logic [NUM_CORES-1:0][31:0] lr_arr;
  logic                       trig_fire;

  assign pc_arr = dbg_pc;
  assign sp_arr = dbg_sp;
  assign lr_arr = dbg_lr;

  core_boot_decode #(
    .NUM_CORES   (NUM_CORES),
    .ADDR_W      (ADDR_W),
    .CLUSTER_BASE(CLUSTER_BASE)
  ) u_decode (
    .addr(reg_addr),
    .kind(kind),
    .idx (idx),
    .word(word)
  );

  core_boot_regs #(
    .NUM_CORES(NUM_CORES),
    .CFG_W    (CFG_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .kind     (kind),
    .idx      (idx),
    .wdata    (reg_wdata),
    .cfg_q    (cfg_q),
    .base_q   (base_q),
    .trig_fire(trig_fire)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_lane
    core_boot_lane u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (trig_fire & cfg_q[g]),
      .base (base_q[g]),
      .run  (core_run[g]),
      .vec  (vec_arr[g])
    );
  end

  assign core_boot_addr = vec_arr;

  core_boot_rdmux #(
    .NUM_CORES(NUM_CORES),
    .CFG_W    (CFG_W)
  ) u_rdmux (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (reg_rd_en),
    .kind  (kind),
    .idx   (idx),
    .word  (word),
    .cfg_q (cfg_q),
    .base_q(base_q),
    .pc_arr(pc_arr),
    .sp_arr(sp_arr),
    .lr_arr(lr_arr),
    .rdata (reg_rdata),
    .rvalid(reg_rvalid)
  );

endmodule

// File: rtl/core_boot_ctrl_chk.sv
module core_boot_ctrl_chk #(
  parameter int                NUM_CORES    = 4,
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] CLUSTER_BASE = 16'h1000
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      reg_wr_en,
  input logic                      reg_rd_en,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [31:0]               reg_wdata,
  input logic [31:0]               reg_rdata,
  input logic                      reg_rvalid,
  input logic [NUM_CORES-1:0]      core_run,
  input logic [NUM_CORES*32-1:0]   core_boot_addr
);

  // R10: data strobe follows the read enable by one cycle
  a_r10_rvalid_timing: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> reg_rvalid == $past(reg_rd_en && rst_n));

  // R5: start register reads as zero
  a_r5_trig_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd_en && rst_n && reg_addr == CLUSTER_BASE) |-> reg_rdata == 32'h0);

  // R10: misaligned reads return zero
  a_r10_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd_en && rst_n && reg_addr[1:0] != 2'b00) |-> reg_rdata == 32'h0);

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    // R6: release is sticky
    a_r6_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      core_run[g] |=> core_run[g]);

    // R4: a release is always caused by a start write with bit 0 set
    a_r4_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_run[g]) |->
        $past(reg_wr_en && reg_addr == CLUSTER_BASE && reg_wdata[0]));

    // R8: lane frozen while the core runs
    a_r8_vec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (core_run[g] && $past(core_run[g])) |-> $stable(core_boot_addr[g*32 +: 32]));
  end

endmodule

bind core_boot_ctrl core_boot_ctrl_chk #(
  .NUM_CORES   (NUM_CORES),
  .ADDR_W      (ADDR_W),
  .CLUSTER_BASE(CLUSTER_BASE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr_en     (reg_wr_en),
  .reg_rd_en     (reg_rd_en),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .reg_rvalid    (reg_rvalid),
  .core_run      (core_run),
  .core_boot_addr(core_boot_addr)
);

// File: tb/core_boot_ctrl_test.sv
module core_boot_ctrl_test;

  localparam int N = 4;
  localparam logic [15:0] A_TRIG = 16'h1000;
  localparam logic [15:0] A_CFG  = 16'h1004;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr_en = 1'b0;
  logic              reg_rd_en = 1'b0;
  logic [15:0]       reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              reg_rvalid;
  logic [N-1:0][31:0] pc_v, sp_v, lr_v;
  logic [N*32-1:0]   dbg_pc, dbg_sp, dbg_lr;
  logic [N-1:0]      core_run;
  logic [N*32-1:0]   core_boot_addr;

  assign dbg_pc = pc_v;
  assign dbg_sp = sp_v;
  assign dbg_lr = lr_v;

  always #4 clk = ~clk;

  core_boot_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .dbg_pc(dbg_pc), .dbg_sp(dbg_sp), .dbg_lr(dbg_lr),
    .core_run(core_run), .core_boot_addr(core_boot_addr)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0]  m_cfg;
  logic [31:0] m_base [N];
  logic [31:0] m_cap  [N];
  logic [N-1:0] m_run;

  function automatic logic [15:0] a_base(int i);
    return 16'h1020 + 16'(4 * i);
  endfunction

  function automatic logic [31:0] exp_vec(int i);
    return m_run[i] ? m_cap[i] : m_base[i];
  endfunction

  function automatic logic [31:0] exp_read(logic [15:0] a);
    logic [7:0] pg, of;
    pg = a[15:8];
    of = a[7:0];
    if (a[1:0] != 2'b00) return 32'h0;
    if (pg == 8'h10) begin
      if (of == 8'h04) return {24'h0, m_cfg};
      if (of >= 8'h20 && of <= 8'h2C) return m_base[(of - 8'h20) / 4];
      return 32'h0;
    end
    if (pg < N && of < 8'h0C) begin
      case (of)
        8'h00:   return pc_v[pg];
        8'h04:   return sp_v[pg];
        default: return lr_v[pg];
      endcase
    end
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cfg = '0;
    m_run = '0;
    for (int i = 0; i < N; i++) begin
      m_base[i] = '0;
      m_cap[i]  = '0;
    end
  endtask

  task automatic model_write(logic [15:0] a, logic [31:0] d);
    if (a == A_CFG) m_cfg = d[7:0];
    else if (a == A_TRIG && d[0]) begin
      for (int i = 0; i < N; i++)
        if (m_cfg[i] && !m_run[i]) begin
          m_run[i] = 1'b1;
          m_cap[i] = m_base[i];
        end
    end else begin
      for (int i = 0; i < N; i++)
        if (a == a_base(i)) m_base[i] = d;
    end
  endtask

  task automatic check_cores(string tag);
    chk({tag, " run"}, 32'(core_run), 32'(m_run));
    for (int i = 0; i < N; i++)
      chk({tag, " lane"}, core_boot_addr[i*32 +: 32], exp_vec(i));
  endtask

  task automatic do_write(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(logic [15:0] a, string tag);
    logic [31:0] e;
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    e = exp_read(a);
    @(negedge clk);
    reg_rd_en = 1'b0;
    chk({tag, " rvalid"}, 32'(reg_rvalid), 32'd1);
    chk(tag, reg_rdata, e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      pc_v[i] = 32'h1000_0000 + 32'(i);
      sp_v[i] = 32'h2000_0000 + 32'(i);
      lr_v[i] = 32'h3000_0000 + 32'(i);
    end
    void'($urandom(32'd20250611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_cores("R1");
    chk("R1 rvalid", 32'(reg_rvalid), 32'd0);
    do_read(A_CFG, "R1 cfg");
    do_read(a_base(2), "R1 base");

    // R2: only low 8 bits kept
    do_write(A_CFG, 32'hABCD_EF5A);
    do_read(A_CFG, "R2 cfg");

    // R3: each start address
    for (int i = 0; i < N; i++) do_write(a_base(i), 32'h8000_0000 + 32'(i << 12));
    for (int i = 0; i < N; i++) do_read(a_base(i), "R3 base");
    check_cores("R8 held follows");

    // R4: bit0 clear releases nothing, high mask bits release nothing
    do_write(A_CFG, 32'hF7);
    do_write(A_TRIG, 32'hFFFF_FFFE);
    check_cores("R4 bit0 clear");
    do_write(A_CFG, 32'hF0);
    do_write(A_TRIG, 32'h1);
    check_cores("R4 high bits");

    // R7: 0xF7 keeps core 3 held
    do_write(A_CFG, 32'hF7);
    do_write(A_TRIG, 32'h1);
    chk("R7 run", 32'(core_run), 32'h7);
    check_cores("R7");
    do_read(A_TRIG, "R5 trig");

    // R8: rewrite running core 0 and held core 3
    do_write(a_base(0), 32'hDEAD_0000);
    do_write(a_base(3), 32'hBEEF_0003);
    do_read(a_base(0), "R8 stored");
    chk("R8 frozen", core_boot_addr[31:0], 32'h8000_0000);
    chk("R8 follows", core_boot_addr[127:96], 32'hBEEF_0003);

    // R6: later start adds core 3 only
    do_write(A_CFG, 32'h08);
    do_write(A_TRIG, 32'h1);
    chk("R6 run", 32'(core_run), 32'hF);
    check_cores("R6");

    // R9: debug windows
    for (int i = 0; i < N; i++)
      for (int w = 0; w < 3; w++)
        do_read(16'(i * 256 + w * 4), "R9 dbg");

    // R10: unmapped reads
    do_read(16'h000C, "R10 dbg hole");
    do_read(16'h2000, "R10 far");
    do_read(16'h1008, "R10 cluster hole");
    do_read(16'h1030, "R10 past bases");
    do_read(16'h1005, "R10 misaligned");

    // R11: writes to debug and unmapped space change nothing
    do_reset();
    do_write(A_CFG, 32'h05);
    do_write(16'h0000, 32'h1);
    do_write(16'h1008, 32'hFFFF_FFFF);
    do_write(16'h1001, 32'h1);
    do_write(16'h1024 + 16'h1, 32'h1234_5678);
    check_cores("R11");
    do_read(A_CFG, "R11 cfg");
    for (int i = 0; i < N; i++) do_read(a_base(i), "R11 base");

    // random phase
    do_reset();
    for (int k = 0; k < 800; k++) begin
      int op;
      op = int'($urandom % 8);
      for (int i = 0; i < N; i++) pc_v[i] = $urandom;
      case (op)
        0: do_write(A_CFG, ($urandom % 4 == 0) ? 32'hF7 : $urandom);
        1, 2: do_write(a_base(int'($urandom % N)), $urandom);
        3: do_write(A_TRIG, $urandom);
        4: do_read(16'($urandom % 16'h1040), "R10 random read");
        5: do_read(a_base(int'($urandom % N)), "R3 random read");
        6: do_write(16'($urandom % 16'h0400), $urandom);
        default: if ($urandom % 40 == 0) do_reset(); else do_read(A_CFG, "R2 random read");
      endcase
      check_cores("R8 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule